// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block sets the timing of a multi-channel sampling frame on a slow clock. An input multiplexer visits a programmable number of slots, one after another. Each slot is converted over a whole number of slow-clock cycles, and the filter-length setting decides how many. After the last conversion the block adds a single quiet cycle so that the reference can settle. Then the next frame begins.

At the start of every frame the block pulses a frame-sync strobe and a compute-pass-start strobe. Both are locked to the moment the slot-0 conversion begins. A conversion-done strobe marks the last cycle of every conversion. A transfer-busy flag covers one whole frame once every presample-count times sum-cycle-count passes. All settings are sampled only at a frame boundary, so a change made in the middle of a frame never bends the frame in progress. The converter and the compute engine sit outside this block.

Top module: `muxFrameSeq`

## Requirements
- R1: The active slot count is `slotCount`, with 0 treated as 1; `slotIdx` steps 0, 1, …, count−1 in each frame, one step per conversion.
- R2: A conversion lasts `filterLen`+1 slow-clock cycles, with code 3 treated as 2 (so 1, 2 or 3 cycles); `convDone` is high for exactly the last cycle of each conversion.
- R3: A frame lasts 1 + count × conversion length cycles (for example 7, 13 or 19 cycles with 6 slots).
- R4: After the last conversion comes exactly one recovery cycle, during which `slotIdx` holds count−1 and `convDone`, `frameSync` and `passStart` are low.
- R5: `frameSync` and `passStart` are both high for exactly the first cycle of each frame, with `slotIdx` = 0. The first frame starts in the first cycle after reset is released.
- R6: Let P be `preSamps` × `sumCycles`, with a product of 0 treated as 1. Number the frames from 1 after reset. `xferBusy` is high for the whole of every frame whose number is a multiple of P, and low in all other frames.
- R7: A change to `slotCount` or `filterLen` made inside a frame takes effect only at the next frame start.
- R8: While `rstN` is low, `slotIdx` is 0 and `convDone`, `frameSync`, `passStart` and `xferBusy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | slow sampling clock |
| rstN | input | 1 | asynchronous reset, active low |
| slotCount | input | 4 | number of multiplexer slots per frame |
| filterLen | input | 2 | filter length code; conversion takes code+1 cycles |
| preSamps | input | 8 | presample count |
| sumCycles | input | 8 | sum-cycle count |
| slotIdx | output | 4 | slot currently being converted |
| convDone | output | 1 | last cycle of a conversion |
| frameSync | output | 1 | first cycle of a frame |
| passStart | output | 1 | start of a compute pass |
| xferBusy | output | 1 | transfer-busy flag, one frame long |

## Verification
When a conversion takes one cycle, the frame start and the end of the slot-0 conversion fall in the same cycle. `frameSync`, `passStart` and `convDone` must then all be high together, and with a single slot the recovery cycle follows at once. The bench provokes this with `filterLen` = 0 at slot counts of 1 and 0. It compares every cycle of several frames with a frame shape worked out from the requirements, and it reports any missing or extra strobe in that shared cycle.

// File: rtl/muxSeqPkg.sv
package muxSeqPkg;
  typedef struct packed {
    logic frameStart;
    logic convEnd;
    logic frameEnd;
  } seqStrobeT;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import muxSeqPkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int FLEN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] slotCount,
  input  logic [FLEN_W-1:0] filterLen,
  output logic [SLOT_W-1:0] slotIdx,
  output seqStrobeT         strobe
);
  localparam int CONV_MAX = 3;
  localparam int CYC_W = $clog2(CONV_MAX + 1);

  logic [SLOT_W-1:0] slotQ, nSlotsQ, nSlotsLive, nSlotsEff;
  logic [CYC_W-1:0]  cycQ, convLenQ, convLenLive, convLenEff;
  logic              recQ, frameStart, convEnd, lastSlot;

  always_comb begin
    nSlotsLive  = (slotCount == '0) ? SLOT_W'(1) : slotCount;
    convLenLive = (filterLen >= FLEN_W'(2)) ? CYC_W'(CONV_MAX) : CYC_W'(filterLen) + CYC_W'(1);
    frameStart  = (slotQ == '0) && (cycQ == '0) && !recQ;
    nSlotsEff   = frameStart ? nSlotsLive : nSlotsQ;
    convLenEff  = frameStart ? convLenLive : convLenQ;
    convEnd     = !recQ && (cycQ == convLenEff - CYC_W'(1));
    lastSlot    = (slotQ == nSlotsEff - SLOT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ    <= '0;
      cycQ     <= '0;
      recQ     <= 1'b0;
      nSlotsQ  <= SLOT_W'(1);
      convLenQ <= CYC_W'(1);
    end else begin
      if (frameStart) begin
        nSlotsQ  <= nSlotsLive;
        convLenQ <= convLenLive;
      end
      if (recQ) begin
        recQ  <= 1'b0;
        slotQ <= '0;
        cycQ  <= '0;
      end else if (convEnd) begin
        cycQ <= '0;
        if (lastSlot) recQ <= 1'b1;
        else          slotQ <= slotQ + SLOT_W'(1);
      end else begin
        cycQ <= cycQ + CYC_W'(1);
      end
    end
  end

  assign slotIdx = slotQ;
  assign strobe  = '{frameStart: frameStart, convEnd: convEnd, frameEnd: recQ};

  p_slot_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |-> (slotQ < nSlotsQ));
  p_cyc_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |-> (cycQ < convLenQ));
  p_single_recovery_r4: assert property (@(posedge clk) disable iff (!rstN)
    recQ |=> (!recQ && frameStart));
  p_recovery_after_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    (convEnd && lastSlot) |=> recQ);
endmodule

// File: rtl/seqData.sv
module seqData
  import muxSeqPkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] preSamps,
  input  logic [SUM_W-1:0] sumCycles,
  input  seqStrobeT        strobe,
  output logic             xferBusy
);
  localparam int PER_W = PRE_W + SUM_W;

  logic [PER_W-1:0] prod, periodLive, periodQ, periodEff, passQ;

  always_comb begin
    prod       = PER_W'(preSamps) * PER_W'(sumCycles);
    periodLive = (prod == '0) ? PER_W'(1) : prod;
    periodEff  = strobe.frameStart ? periodLive : periodQ;
    xferBusy   = (passQ == periodEff - PER_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= PER_W'(1);
      passQ   <= '0;
    end else begin
      if (strobe.frameStart) periodQ <= periodLive;
      if (strobe.frameEnd)
        passQ <= (passQ >= periodQ - PER_W'(1)) ? '0 : passQ + PER_W'(1);
    end
  end

  p_xfer_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(xferBusy) || $fell(xferBusy)) |-> strobe.frameStart);
endmodule

// File: rtl/muxFrameSeq.sv
module muxFrameSeq
  import muxSeqPkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int FLEN_W = 2,
  parameter int PRE_W  = 8,
  parameter int SUM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] slotCount,
  input  logic [FLEN_W-1:0] filterLen,
  input  logic [PRE_W-1:0]  preSamps,
  input  logic [SUM_W-1:0]  sumCycles,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              convDone,
  output logic              frameSync,
  output logic              passStart,
  output logic              xferBusy
);
  seqStrobeT strobe;
  logic      busyInt;

  seqCtrl #(.SLOT_W(SLOT_W), .FLEN_W(FLEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .slotCount(slotCount), .filterLen(filterLen),
    .slotIdx(slotIdx), .strobe(strobe));

  seqData #(.PRE_W(PRE_W), .SUM_W(SUM_W)) data_i (
    .clk(clk), .rstN(rstN), .preSamps(preSamps), .sumCycles(sumCycles),
    .strobe(strobe), .xferBusy(busyInt));

  assign convDone  = rstN & strobe.convEnd;
  assign frameSync = rstN & strobe.frameStart;
  assign passStart = rstN & strobe.frameStart;
  assign xferBusy  = rstN & busyInt;

  p_quiet_recovery_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameEnd |-> (!convDone && !frameSync && !passStart));
endmodule

// File: tb/muxFrameSeq_tb_top.sv
module muxFrameSeq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] slotCount = 4'd1;
  logic [1:0] filterLen = 2'd0;
  logic [7:0] preSamps = 8'd1;
  logic [7:0] sumCycles = 8'd1;
  logic [3:0] slotIdx;
  logic       convDone, frameSync, passStart, xferBusy;
  int         nChecks = 0;
  int         nFails = 0;

  always #4 clk = ~clk;

  muxFrameSeq dut_i (
    .clk(clk), .rstN(rstN), .slotCount(slotCount), .filterLen(filterLen),
    .preSamps(preSamps), .sumCycles(sumCycles), .slotIdx(slotIdx),
    .convDone(convDone), .frameSync(frameSync), .passStart(passStart),
    .xferBusy(xferBusy));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R8 checks while reset is held; leaves the bench in the first frame cycle
  task automatic doReset(input logic [3:0] n, input logic [1:0] f, input logic [7:0] ps, input logic [7:0] sc);
    @(negedge clk);
    rstN = 1'b0;
    slotCount = n; filterLen = f; preSamps = ps; sumCycles = sc;
    repeat (2) @(negedge clk);
    #1;
    chk("R8", {4'd0, slotIdx}, 8'd0, "slotIdx in reset");
    chk("R8", {4'd0, convDone, frameSync, passStart, xferBusy}, 8'd0, "strobes in reset");
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  // one frame, checked cycle by cycle; optionally changes settings at cycle chgAt
  task automatic checkFrame(input int n, input int len, input logic busy, input string req,
                            input int chgAt, input logic [3:0] newN, input logic [1:0] newF);
    int cyc = 0;
    for (int s = 0; s < n; s++) begin
      for (int c = 0; c < len; c++) begin
        if (cyc == chgAt) begin slotCount = newN; filterLen = newF; #1; end
        chk(req, {4'd0, slotIdx}, 8'(s), "slotIdx");
        chk(req, {7'd0, convDone}, 8'(c == len - 1), "convDone");
        chk(req, {7'd0, frameSync}, 8'(s == 0 && c == 0), "frameSync");
        chk(req, {7'd0, passStart}, 8'(s == 0 && c == 0), "passStart");
        chk("R6", {7'd0, xferBusy}, {7'd0, busy}, "xferBusy");
        cyc++;
        @(negedge clk); #1;
      end
    end
    // R4 recovery cycle
    chk("R4", {4'd0, slotIdx}, 8'(n - 1), "slotIdx in recovery");
    chk("R4", {5'd0, convDone, frameSync, passStart}, 8'd0, "strobes in recovery");
    chk("R6", {7'd0, xferBusy}, {7'd0, busy}, "xferBusy in recovery");
    @(negedge clk); #1;
    chk("R3", {7'd0, frameSync}, 8'd1, "next frame start after 1+n*len cycles");
  endtask

  task automatic testShapes();
    doReset(4'd6, 2'd0, 8'd1, 8'd1);
    checkFrame(6, 1, 1'b1, "R3", -1, 4'd0, 2'd0);
    doReset(4'd6, 2'd1, 8'd1, 8'd1);
    checkFrame(6, 2, 1'b1, "R2", -1, 4'd0, 2'd0);
    doReset(4'd6, 2'd2, 8'd1, 8'd1);
    checkFrame(6, 3, 1'b1, "R2", -1, 4'd0, 2'd0);
    doReset(4'd15, 2'd3, 8'd1, 8'd1);
    checkFrame(15, 3, 1'b1, "R2", -1, 4'd0, 2'd0);
  endtask

  task automatic testCoincide();
    doReset(4'd1, 2'd0, 8'd1, 8'd1);
    checkFrame(1, 1, 1'b1, "R5", -1, 4'd0, 2'd0);
    checkFrame(1, 1, 1'b1, "R5", -1, 4'd0, 2'd0);
    doReset(4'd0, 2'd0, 8'd1, 8'd1);
    checkFrame(1, 1, 1'b1, "R1", -1, 4'd0, 2'd0);
    doReset(4'd3, 2'd0, 8'd1, 8'd1);
    checkFrame(3, 1, 1'b1, "R5", -1, 4'd0, 2'd0);
  endtask

  task automatic testXfer();
    doReset(4'd2, 2'd1, 8'd2, 8'd2);
    for (int k = 1; k <= 8; k++) checkFrame(2, 2, (k % 4) == 0, "R6", -1, 4'd0, 2'd0);
    doReset(4'd3, 2'd0, 8'd3, 8'd1);
    for (int k = 1; k <= 6; k++) checkFrame(3, 1, (k % 3) == 0, "R6", -1, 4'd0, 2'd0);
    doReset(4'd2, 2'd0, 8'd0, 8'd5);
    for (int k = 1; k <= 3; k++) checkFrame(2, 1, 1'b1, "R6", -1, 4'd0, 2'd0);
  endtask

  task automatic testMidChange();
    doReset(4'd3, 2'd1, 8'd1, 8'd1);
    checkFrame(3, 2, 1'b1, "R7", 2, 4'd2, 2'd0);
    checkFrame(2, 1, 1'b1, "R7", -1, 4'd0, 2'd0);
    checkFrame(2, 1, 1'b1, "R7", 1, 4'd5, 2'd2);
    checkFrame(5, 3, 1'b1, "R7", -1, 4'd0, 2'd0);
  endtask

  initial begin
    fork
      begin
        testShapes();
        testCoincide();
        testXfer();
        testMidChange();
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual running expected finished");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule